// File: doc/BRIEF.md
# Hardware sync point counter bank

This block holds a small bank of event counters, here called sync points. Each counter counts the occurrences of its own hardware event pulse. Software can also add one to any set of counters through a register write, and the effect is the same as a hardware event. A single routing register can steer a video VSYNC pulse onto any one counter, chosen by index. Software polls any counter at any time through a plain register bus with address, write data, write strobe and combinational read data. Reads have no side effects.

Every counter has a threshold and an arm bit of its own. While a counter is armed, its interrupt line rises once the counter has reached the threshold. The comparison takes the 32-bit difference between value and threshold as a signed number, so it stays correct across wraparound. The interrupt is a level. It stays set until software writes a one to the counter's bit in the clear register, or disarms the counter.

Register map (byte-free word addresses on an 8-bit bus):

| Address | Access | Meaning |
|---|---|---|
| 0x00 + i | read | current value of counter i |
| 0x10 + i | read/write | threshold of counter i |
| 0x20 | write | bit i = 1 adds one to counter i (reads 0) |
| 0x21 | read/write | bit i arms counter i |
| 0x22 | write-1-to-clear / read | interrupt status, bit i for counter i |
| 0x23 | read/write | VSYNC route: bit 8 enable, bits 7:0 counter index |

Top module: `syncpt_bank`

## Requirements
- R1: A one-cycle pulse on hw_evt[i] adds exactly one to counter i, and pulses on several inputs in one cycle each advance their own counter.
- R2: A write to 0x20 adds one to every counter whose bit is 1 in the write data; address 0x20 reads back 0.
- R3: Increments that hit one counter in the same cycle add up: a hardware event plus a manual increment adds two, and with a routed VSYNC as well it adds three.
- R4: Reading 0x00+i returns counter i's current value, and repeated reads leave every counter unchanged.
- R5: A write to 0x10+i stores the threshold of counter i, which reads back unchanged at the same address.
- R6: While bit i of 0x21 is set, irq[i] rises one clock after counter i first holds a value whose difference from the threshold, taken as a signed 32-bit number, is non-negative; a threshold far "behind" the value across wraparound therefore counts as reached.
- R7: Writing 1 to bit i of 0x22 drops irq[i] at that clock edge; the flag sets again one clock later if counter i is still armed and at or past its threshold, and other bits are unaffected.
- R8: Writing 0 to bit i of 0x21 drops irq[i] at that clock edge.
- R9: While bit 8 of 0x23 is set, every VSYNC pulse adds one to the counter named by bits 7:0, starting the cycle after the write; the register reads back its 9 bits.
- R10: A VSYNC pulse moves no counter when routing is disabled or the index is 8 or more.
- R11: After reset all counters, thresholds, arm bits, interrupts and the route register are zero; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hw_evt | input | 8 | One pulse per hardware event, one bit per counter |
| vsync | input | 1 | VSYNC pulse, one cycle per occurrence |
| irq | output | 8 | Interrupt level per counter |

## Verification
The bench builds the block with its defaults: 8 counters of 32 bits and an 8-bit route index. The 8-bit index lets the bench reach indices 8 to 255, which must leave every counter untouched. The 32-bit width cannot wrap within the run. Wraparound is instead shown through thresholds placed just below 2^32 and at 2^31, where the signed difference decides whether the threshold counts as reached. A long random phase mixes events, manual increments, threshold moves, arm and clear writes and VSYNC routing against a per-cycle reference model.

// File: rtl/syncpt_pkg.sv
package syncpt_pkg;
   localparam int ADDR_W = 8;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t ADR_CNT    = 8'h00;
   localparam addr_t ADR_THR    = 8'h10;
   localparam addr_t ADR_MANINC = 8'h20;
   localparam addr_t ADR_ARM    = 8'h21;
   localparam addr_t ADR_CLR    = 8'h22;
   localparam addr_t ADR_ROUTE  = 8'h23;

   localparam int IDX_W = 8;
   typedef struct packed {
      logic             en;   // bit 8
      logic [IDX_W-1:0] idx;  // bits 7:0
   } route_t;
endpackage

// File: rtl/syncpt_counter.sv
module syncpt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_hw,
   input  logic             inc_sw,
   input  logic             inc_vs,
   input  logic             thr_we,
   input  logic [CNT_W-1:0] thr_wdata,
   input  logic             arm_we,
   input  logic             arm_wbit,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] thresh,
   output logic             armed,
   output logic             irq
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("syncpt_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] count_q, thr_q;
   logic             arm_q, irq_q, arm_nx, reach, irq_d;
   logic [1:0]       step;
   logic [CNT_W-1:0] diff;

   assign step   = {1'b0, inc_hw} + {1'b0, inc_sw} + {1'b0, inc_vs};
   assign diff   = count_q - thr_q;
   assign reach  = ~diff[CNT_W-1];
   assign arm_nx = arm_we ? arm_wbit : arm_q;
   assign irq_d  = arm_nx & ~clr & (irq_q | (arm_q & reach));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         thr_q   <= '0;
         arm_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         count_q <= count_q + CNT_W'(step);
         if (thr_we) thr_q <= thr_wdata;
         arm_q <= arm_nx;
         irq_q <= irq_d;
      end
   end

   assign count  = count_q;
   assign thresh = thr_q;
   assign armed  = arm_q;
   assign irq    = irq_q;

   assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hw && !inc_sw && !inc_vs) |=> count_q == $past(count_q) + CNT_W'(1));
   assert_double_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hw && inc_sw && !inc_vs) |=> count_q == $past(count_q) + CNT_W'(2));
   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_hw && !inc_sw && !inc_vs) |=> $stable(count_q));
   assert_rise_reached_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(arm_q && reach));
   assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !irq_q);
   assert_irq_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> arm_q);
endmodule

// File: rtl/syncpt_route.sv
module syncpt_route #(
   parameter int NUM_PTS = 8,
   parameter int IDX_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vsync,
   input  logic               route_en,
   input  logic [IDX_W-1:0]   route_idx,
   output logic [NUM_PTS-1:0] hit
);
   generate
      if (NUM_PTS > (1 << IDX_W)) begin : g_bad_idx
         $error("syncpt_route: IDX_W too narrow for NUM_PTS");
      end
      for (genvar g = 0; g < NUM_PTS; g++) begin : g_hit
         assign hit[g] = vsync & route_en & (route_idx == IDX_W'(g));
      end
   endgenerate

   assert_route_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   assert_route_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!route_en || int'(route_idx) >= NUM_PTS) |-> hit == '0);
endmodule

// File: rtl/syncpt_bank.sv
module syncpt_bank
   import syncpt_pkg::*;
#(
   parameter int NUM_PTS = 8,
   parameter int CNT_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   input  logic [NUM_PTS-1:0] hw_evt,
   input  logic               vsync,
   output logic [NUM_PTS-1:0] irq
);
   localparam int ROUTE_W = $bits(route_t);

   generate
      if (NUM_PTS < 1 || NUM_PTS > 16) begin : g_bad_num
         $error("syncpt_bank: NUM_PTS must be 1..16");
      end
      if (CNT_W < ROUTE_W || CNT_W < NUM_PTS) begin : g_bad_cw
         $error("syncpt_bank: CNT_W too narrow for control words");
      end
   endgenerate

   route_t             route_q;
   logic [NUM_PTS-1:0] vs_hit, man_inc, clr_bits, thr_we, arm_bits;
   logic               arm_we;
   logic [CNT_W-1:0]   cnt_v [NUM_PTS];
   logic [CNT_W-1:0]   thr_v [NUM_PTS];

   assign arm_we   = bus_wr && bus_addr == ADR_ARM;
   assign man_inc  = (bus_wr && bus_addr == ADR_MANINC) ? bus_wdata[NUM_PTS-1:0] : '0;
   assign clr_bits = (bus_wr && bus_addr == ADR_CLR) ? bus_wdata[NUM_PTS-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) route_q <= '0;
      else if (bus_wr && bus_addr == ADR_ROUTE) route_q <= route_t'(bus_wdata[ROUTE_W-1:0]);
   end

   syncpt_route #(.NUM_PTS(NUM_PTS), .IDX_W(IDX_W)) i_route (
      .clk(clk), .rst_n(rst_n), .vsync(vsync),
      .route_en(route_q.en), .route_idx(route_q.idx), .hit(vs_hit)
   );

   generate
      for (genvar g = 0; g < NUM_PTS; g++) begin : g_pt
         assign thr_we[g] = bus_wr && bus_addr == addr_t'(ADR_THR + g);
         syncpt_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc_hw(hw_evt[g]), .inc_sw(man_inc[g]), .inc_vs(vs_hit[g]),
            .thr_we(thr_we[g]), .thr_wdata(bus_wdata),
            .arm_we(arm_we), .arm_wbit(bus_wdata[g]), .clr(clr_bits[g]),
            .count(cnt_v[g]), .thresh(thr_v[g]), .armed(arm_bits[g]), .irq(irq[g])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PTS; i++) begin
         if (bus_addr == addr_t'(ADR_CNT + i)) bus_rdata = cnt_v[i];
         if (bus_addr == addr_t'(ADR_THR + i)) bus_rdata = thr_v[i];
      end
      if (bus_addr == ADR_ARM)   bus_rdata = CNT_W'(arm_bits);
      if (bus_addr == ADR_CLR)   bus_rdata = CNT_W'(irq);
      if (bus_addr == ADR_ROUTE) bus_rdata = CNT_W'(route_q);
   end

   assert_route_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADR_ROUTE) |=> $stable(route_q));
   assert_maninc_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADR_MANINC) |-> bus_rdata == '0);
endmodule

// File: tb/test_syncpt_bank.sv
module test_syncpt_bank;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] hw_evt = '0;
   logic        vsync = 1'b0;
   logic [N-1:0] irq;

   always #4 clk = ~clk;

   syncpt_bank i_syncpt_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
      .vsync(vsync), .irq(irq)
   );

   int errors = 0, checks = 0;
   bit done = 0;
   string tag = "R11";

   logic [31:0] m_cnt [N];
   logic [31:0] m_thr [N];
   logic [N-1:0] m_arm, m_irq;
   logic [8:0]  m_route;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [7:0] a);
      m_read = 32'h0;
      if (a < 8'(N)) m_read = m_cnt[a];
      else if (a >= 8'h10 && a < 8'h10 + 8'(N)) m_read = m_thr[a - 8'h10];
      else if (a == 8'h21) m_read = 32'(m_arm);
      else if (a == 8'h22) m_read = 32'(m_irq);
      else if (a == 8'h23) m_read = 32'(m_route);
   endfunction

   task automatic m_reset();
      for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_thr[i] = '0; end
      m_arm = '0; m_irq = '0; m_route = '0;
   endtask

   task automatic m_update();
      logic [N-1:0] man, clr, arm_n, reach;
      man = '0; clr = '0; arm_n = m_arm;
      if (bus_wr && bus_addr == 8'h20) man = bus_wdata[N-1:0];
      if (bus_wr && bus_addr == 8'h22) clr = bus_wdata[N-1:0];
      if (bus_wr && bus_addr == 8'h21) arm_n = bus_wdata[N-1:0];
      for (int i = 0; i < N; i++) begin
         int d;
         d = $signed(m_cnt[i] - m_thr[i]);
         reach[i] = (d >= 0);
      end
      for (int i = 0; i < N; i++) begin
         int add;
         add = int'(hw_evt[i]) + int'(man[i]);
         if (vsync && m_route[8] && int'(m_route[7:0]) == i) add++;
         m_cnt[i] = m_cnt[i] + 32'(add);
         m_irq[i] = arm_n[i] && !clr[i] && (m_irq[i] || (m_arm[i] && reach[i]));
         if (bus_wr && bus_addr == 8'h10 + 8'(i)) m_thr[i] = bus_wdata;
      end
      m_arm = arm_n;
      if (bus_wr && bus_addr == 8'h23) m_route = bus_wdata[8:0];
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      m_update();
      chk({tag, " irq"}, 32'(irq), 32'(m_irq));
      chk({tag, " rdata"}, bus_rdata, m_read(bus_addr));
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_wr = 1'b0; bus_addr = a;
      tick();
      v = bus_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      tag = "R11";
      for (int a = 0; a < 8'h30; a++) begin
         rd(8'(a), v);
         chk("R11 reset read", v, 32'h0);
      end
      chk("R11 irq", 32'(irq), 32'h0);

      // R1: hardware events
      tag = "R1";
      hw_evt = 8'b0000_0101;
      repeat (3) tick();
      hw_evt = 8'b0000_0100;
      tick();
      hw_evt = '0;
      rd(8'h00, v); chk("R1 cnt0", v, 32'd3);
      rd(8'h02, v); chk("R1 cnt2", v, 32'd4);
      rd(8'h01, v); chk("R1 cnt1 untouched", v, 32'd0);

      // R2: manual increments
      tag = "R2";
      wr(8'h20, 32'h82);
      wr(8'h20, 32'h82);
      rd(8'h01, v); chk("R2 cnt1", v, 32'd2);
      rd(8'h07, v); chk("R2 cnt7", v, 32'd2);
      rd(8'h20, v); chk("R2 reads zero", v, 32'd0);

      // R3: coincident increments
      tag = "R3";
      wr(8'h23, 32'h103);
      hw_evt = 8'b0000_1000; vsync = 1'b1;
      wr(8'h20, 32'h08);
      hw_evt = '0; vsync = 1'b0;
      rd(8'h03, v); chk("R3 triple add", v, 32'd3);
      hw_evt = 8'b0000_1000;
      wr(8'h20, 32'h08);
      hw_evt = '0;
      rd(8'h03, v); chk("R3 double add", v, 32'd5);

      // R4: reads do not disturb
      tag = "R4";
      rd(8'h00, v); rd(8'h00, v2);
      chk("R4 repeat read", v2, v);
      chk("R4 value", v2, 32'd3);

      // R5: threshold storage
      tag = "R5";
      wr(8'h15, 32'hDEAD_BEEF);
      rd(8'h15, v); chk("R5 thr readback", v, 32'hDEAD_BEEF);

      // R6: threshold interrupt, incl. wraparound
      tag = "R6";
      wr(8'h12, 32'd6);
      wr(8'h14, 32'hFFFF_FFF0);
      wr(8'h16, 32'h8000_0000);
      wr(8'h21, 32'h54);
      tick(); tick();
      chk("R6 cnt2 below thr", 32'(irq[2]), 32'd0);
      chk("R6 wrap reached", 32'(irq[4]), 32'd1);
      chk("R6 half-range not reached", 32'(irq[6]), 32'd0);
      hw_evt = 8'b0000_0100;
      tick(); tick();
      hw_evt = '0;
      chk("R6 no irq same cycle", 32'(irq[2]), 32'd0);
      tick();
      chk("R6 irq one clock later", 32'(irq[2]), 32'd1);
      rd(8'h21, v); chk("R6 arm readback", v, 32'h54);

      // R7: clear
      tag = "R7";
      wr(8'h22, 32'h10);
      chk("R7 cleared", 32'(irq[4]), 32'd0);
      chk("R7 other bit kept", 32'(irq[2]), 32'd1);
      tick();
      chk("R7 resets while reached", 32'(irq[4]), 32'd1);
      wr(8'h14, 32'h100);
      wr(8'h22, 32'h10);
      tick(); tick();
      chk("R7 stays clear", 32'(irq[4]), 32'd0);
      rd(8'h22, v); chk("R7 status", v, 32'h04);

      // R8: disarm
      tag = "R8";
      wr(8'h21, 32'h10);
      chk("R8 disarm drops", 32'(irq[2]), 32'd0);

      // R9: vsync routing
      tag = "R9";
      wr(8'h23, 32'h105);
      rd(8'h05, v2);
      vsync = 1'b1; repeat (3) tick(); vsync = 1'b0;
      rd(8'h05, v); chk("R9 routed count", v, v2 + 32'd3);
      rd(8'h23, v); chk("R9 route readback", v, 32'h105);

      // R10: ignored routes
      tag = "R10";
      wr(8'h23, 32'h10A);
      vsync = 1'b1; repeat (4) tick(); vsync = 1'b0;
      rd(8'h05, v); chk("R10 out-of-range index", v, v2 + 32'd3);
      wr(8'h23, 32'h005);
      vsync = 1'b1; repeat (4) tick(); vsync = 1'b0;
      rd(8'h05, v); chk("R10 disabled route", v, v2 + 32'd3);
      for (int i = 0; i < N; i++) begin
         rd(8'(i), v); chk("R10 all counters", v, m_cnt[i]);
      end

      // mixed traffic against the model (R1 R2 R3 R6 R7 R8 R9)
      tag = "R6-mix";
      for (int k = 0; k < 4000; k++) begin
         int sel;
         hw_evt = 8'($urandom);
         vsync = ($urandom % 3) == 0;
         sel = $urandom % 8;
         bus_wr = ($urandom % 3) == 0;
         case (sel)
            0: begin bus_addr = 8'h20; bus_wdata = $urandom; end
            1: begin bus_addr = 8'h21; bus_wdata = $urandom; end
            2: begin bus_addr = 8'h22; bus_wdata = $urandom; end
            3: begin bus_addr = 8'h23; bus_wdata = {23'h0, 1'($urandom), 8'($urandom % 12)}; end
            4: begin bus_addr = 8'h10 + 8'($urandom % N);
                     bus_wdata = m_cnt[bus_addr - 8'h10] + 32'($urandom % 16) - 32'd6; end
            5: begin bus_addr = 8'($urandom % 48); bus_wdata = $urandom; end
            default: begin bus_addr = 8'($urandom % N); bus_wdata = $urandom; end
         endcase
         tick();
      end
      bus_wr = 1'b0; hw_evt = '0; vsync = 1'b0;
      tick();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule